// File: doc/BRIEF.md
# System Bus Address Decoder with Boot Remap

This block sits between a single bus master and the slaves of a 32-bit system bus and turns each request address into a registered one-hot slave select. The top four address bits pick one of sixteen 256 MB banks. Six of them go to external chip selects, one goes to the external DRAM controller and one goes to the peripheral bridge. Bank 0 holds the on-chip memories and gets a second decode into 1 MB regions. Banks and regions that nothing occupies return an error response to the master.

A one-cycle remap pulse moves the on-chip SRAM into the boot window at address zero. Before the remap, that window shows the boot ROM. The SRAM stays reachable at its own region the whole time. A configuration input adds one wait state to accesses aimed at the two tightly-coupled memory regions.

The master raises `req_valid` with an address while the block is idle. The block answers with a one-cycle `rsp_ready` pulse, with the select held until that pulse ends.

Top module: `sysbus_addr_decoder`

## Requirements
- R1: Banks 1 through 6 (address bits [31:28]) drive `slave_sel` bits 0 through 5 respectively; each maps to one external chip select.
- R2: Bank 7 drives `slave_sel` bit 6 (DRAM controller) and bank 15 drives bit 7 (peripheral bridge).
- R3: In bank 0, address bits [27:20] select a region. Regions 1, 2, 3, 4, 5, 6, 7 and 8 drive `slave_sel` bits 9 (instruction TCM), 10 (data TCM), 11 (SRAM), 8 (ROM), 12 (display controller), 13 (USB device DMA), 14 (USB host full-speed) and 15 (USB host high-speed). The SRAM region answers whether or not the remap has happened.
- R4: Before any remap, bank-0 region 0 (the boot window) selects the ROM, which is `slave_sel` bit 8.
- R5: A one-cycle high on `remap_pulse` makes the boot window select the SRAM (`slave_sel` bit 11) for every later request. Only a reset undoes this.
- R6: Banks 8 to 14, and bank-0 regions 9 and above, give a response with `rsp_ready` and `rsp_error` both high and `slave_sel` all zero.
- R7: A request accepted at a clock edge is answered in the next cycle: `rsp_ready` is high for exactly that one cycle. `slave_sel` is one-hot or zero, is held from the cycle after acceptance through the ready cycle, and is zero when idle.
- R8: While `tcm_wait_en` is high at acceptance, a request to either TCM region gets `rsp_ready` one cycle later, two cycles after acceptance, with the select held during the wait cycle. Other targets are unaffected.
- R9: During and right after reset, `slave_sel` is zero, `rsp_ready` and `rsp_error` are low, and the remap state is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, accepted while idle |
| req_addr | input | 32 | Request byte address |
| remap_pulse | input | 1 | One-cycle command that maps SRAM at address zero |
| tcm_wait_en | input | 1 | Adds one wait state to TCM accesses |
| slave_sel | output | 16 | Registered one-hot slave select |
| rsp_ready | output | 1 | One-cycle response strobe |
| rsp_error | output | 1 | Abort flag, valid with `rsp_ready` |

## Verification
The bench covers the base and top address of every bank and of every bank-0 region, in four combinations of remap and wait state. A decoder that compared too few address bits would let bank-0 addresses past region 8, or the very top of bank 0, alias a real memory instead of aborting. Remap is tested both ways: a latch that failed to hold would put the boot window back on the ROM, and one that moved SRAM instead of aliasing it would break the SRAM region at its own address. The wait state is checked on TCM and non-TCM targets, to catch a stall applied to everything or not at all. A reset after remap must bring the ROM back at address zero.

// File: rtl/sbd_pkg.sv
package sbd_pkg;
    localparam int ADDR_W         = 32;
    localparam int BANK_W         = 4;
    localparam int REGION_LSB     = 20;
    localparam int REGION_W       = ADDR_W - BANK_W - REGION_LSB;
    localparam int N_SLAVES       = 16;
    localparam int SEL_IDX_W      = $clog2(N_SLAVES);
    localparam int N_EXT_CS       = 6;
    localparam int EXT_BANK_FIRST = 1;
    localparam int DRAM_BANK      = 7;
    localparam int BRIDGE_BANK    = 15;
    localparam int INTERNAL_BANK  = 0;

    typedef logic [SEL_IDX_W-1:0] slave_idx_t;

    localparam slave_idx_t S_DRAM   = 4'd6;
    localparam slave_idx_t S_BRIDGE = 4'd7;
    localparam slave_idx_t S_ROM    = 4'd8;
    localparam slave_idx_t S_ITCM   = 4'd9;
    localparam slave_idx_t S_DTCM   = 4'd10;
    localparam slave_idx_t S_SRAM   = 4'd11;
    localparam slave_idx_t S_LCD    = 4'd12;
    localparam slave_idx_t S_USBDEV = 4'd13;
    localparam slave_idx_t S_HOST_A = 4'd14;
    localparam slave_idx_t S_HOST_B = 4'd15;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WAIT = 2'd1,
        ST_RESP = 2'd2
    } phase_e;

    typedef struct packed {
        phase_e              phase;
        logic [N_SLAVES-1:0] sel;
        logic                err;
        logic                remapped;
    } dec_state_t;
endpackage

// File: rtl/sbd_bank_decode.sv
module sbd_bank_decode
    import sbd_pkg::*;
(
    input  logic [BANK_W-1:0] bank_i,
    output slave_idx_t        idx_o,
    output logic              hit_o,
    output logic              internal_o
);
    localparam logic [BANK_W-1:0] EXT_LO = BANK_W'(EXT_BANK_FIRST);
    localparam logic [BANK_W-1:0] EXT_HI = BANK_W'(EXT_BANK_FIRST + N_EXT_CS - 1);

    always_comb begin
        idx_o      = '0;
        hit_o      = 1'b0;
        internal_o = 1'b0;
        if (bank_i == BANK_W'(INTERNAL_BANK)) begin
            internal_o = 1'b1;
        end else if (bank_i >= EXT_LO && bank_i <= EXT_HI) begin
            idx_o = SEL_IDX_W'(bank_i - EXT_LO);
            hit_o = 1'b1;
        end else if (bank_i == BANK_W'(DRAM_BANK)) begin
            idx_o = S_DRAM;
            hit_o = 1'b1;
        end else if (bank_i == BANK_W'(BRIDGE_BANK)) begin
            idx_o = S_BRIDGE;
            hit_o = 1'b1;
        end
    end
endmodule

// File: rtl/sbd_region_decode.sv
module sbd_region_decode
    import sbd_pkg::*;
(
    input  logic [REGION_W-1:0] region_i,
    input  logic                remapped_i,
    output slave_idx_t          idx_o,
    output logic                hit_o,
    output logic                tcm_o
);
    always_comb begin
        idx_o = '0;
        hit_o = 1'b1;
        tcm_o = 1'b0;
        case (region_i)
            REGION_W'(0): idx_o = remapped_i ? S_SRAM : S_ROM;
            REGION_W'(1): begin idx_o = S_ITCM; tcm_o = 1'b1; end
            REGION_W'(2): begin idx_o = S_DTCM; tcm_o = 1'b1; end
            REGION_W'(3): idx_o = S_SRAM;
            REGION_W'(4): idx_o = S_ROM;
            REGION_W'(5): idx_o = S_LCD;
            REGION_W'(6): idx_o = S_USBDEV;
            REGION_W'(7): idx_o = S_HOST_A;
            REGION_W'(8): idx_o = S_HOST_B;
            default:      hit_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/sysbus_addr_decoder.sv
module sysbus_addr_decoder
    import sbd_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    input  logic [ADDR_W-1:0]   req_addr,
    input  logic                remap_pulse,
    input  logic                tcm_wait_en,
    output logic [N_SLAVES-1:0] slave_sel,
    output logic                rsp_ready,
    output logic                rsp_error
);
    dec_state_t q, d;

    slave_idx_t bank_idx, region_idx, tgt_idx;
    logic       bank_hit, bank_internal, region_hit, region_tcm;
    logic       tgt_hit, need_wait;
    logic [N_SLAVES-1:0] tgt_onehot;

    sbd_bank_decode u_bank (
        .bank_i     (req_addr[ADDR_W-1 -: BANK_W]),
        .idx_o      (bank_idx),
        .hit_o      (bank_hit),
        .internal_o (bank_internal)
    );

    sbd_region_decode u_region (
        .region_i   (req_addr[REGION_LSB +: REGION_W]),
        .remapped_i (q.remapped),
        .idx_o      (region_idx),
        .hit_o      (region_hit),
        .tcm_o      (region_tcm)
    );

    assign tgt_idx   = bank_internal ? region_idx : bank_idx;
    assign tgt_hit   = bank_internal ? region_hit : bank_hit;
    assign need_wait = bank_internal & region_hit & region_tcm & tcm_wait_en;

    for (genvar g = 0; g < N_SLAVES; g++) begin : g_onehot
        assign tgt_onehot[g] = tgt_hit && (tgt_idx == SEL_IDX_W'(g));
    end

    always_comb begin
        d = q;
        if (remap_pulse) d.remapped = 1'b1;
        case (q.phase)
            ST_IDLE: begin
                if (req_valid) begin
                    d.sel   = tgt_onehot;
                    d.err   = !tgt_hit;
                    d.phase = need_wait ? ST_WAIT : ST_RESP;
                end
            end
            ST_WAIT: d.phase = ST_RESP;
            ST_RESP: begin
                d.phase = ST_IDLE;
                d.sel   = '0;
                d.err   = 1'b0;
            end
            default: begin
                d.phase = ST_IDLE;
                d.sel   = '0;
                d.err   = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.phase    <= ST_IDLE;
            q.sel      <= '0;
            q.err      <= 1'b0;
            q.remapped <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign slave_sel = q.sel;
    assign rsp_ready = (q.phase == ST_RESP);
    assign rsp_error = q.err;

    p_sel_onehot_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(slave_sel));
    p_err_no_sel_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_error |-> (slave_sel == '0));
    p_err_with_ready_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_error |-> rsp_ready);
    p_ready_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_ready |=> !rsp_ready);
    p_remap_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
        q.remapped |=> q.remapped);
    p_fast_latency_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (q.phase == ST_IDLE && req_valid && !need_wait) |=> rsp_ready);
    p_slow_latency_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (q.phase == ST_IDLE && req_valid && need_wait) |=> (!rsp_ready && slave_sel != '0));
endmodule

// File: tb/sysbus_addr_decoder_tb_top.sv
module sysbus_addr_decoder_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [31:0] req_addr = '0;
    logic        remap_pulse = 1'b0;
    logic        tcm_wait_en = 1'b0;
    logic [15:0] slave_sel;
    logic        rsp_ready;
    logic        rsp_error;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    sysbus_addr_decoder dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .remap_pulse(remap_pulse), .tcm_wait_en(tcm_wait_en),
        .slave_sel(slave_sel), .rsp_ready(rsp_ready), .rsp_error(rsp_error)
    );

    // codes: 0..15 slave bit, 16 abort, 17 boot window, 18 second-level decode
    localparam logic [4:0] BANK_CODE [16] = '{
        5'd18, 5'd0, 5'd1, 5'd2, 5'd3, 5'd4, 5'd5, 5'd6,
        5'd16, 5'd16, 5'd16, 5'd16, 5'd16, 5'd16, 5'd16, 5'd7 };
    localparam logic [4:0] REGION_CODE [16] = '{
        5'd17, 5'd9, 5'd10, 5'd11, 5'd8, 5'd12, 5'd13, 5'd14,
        5'd15, 5'd16, 5'd16, 5'd16, 5'd16, 5'd16, 5'd16, 5'd16 };

    function automatic string tag_of(input logic [4:0] code, input bit remapped);
        if (code == 5'd16) return "R6";
        if (code == 5'd17) return remapped ? "R5" : "R4";
        if (code <= 5'd5)  return "R1";
        if (code <= 5'd7)  return "R2";
        return "R3";
    endfunction

    task automatic check(input string tag, input string what,
                         input logic [17:0] act, input logic [17:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic run_req(input logic [31:0] addr, input logic [4:0] code,
                           input bit remapped, input bit wait_on);
        int idx;
        bit err;
        logic [15:0] esel;
        string tag;
        tag  = tag_of(code, remapped);
        err  = (code == 5'd16);
        idx  = (code == 5'd17) ? (remapped ? 11 : 8) : int'(code);
        esel = err ? 16'h0 : (16'h1 << idx);
        @(negedge clk);
        req_valid = 1'b1;
        req_addr  = addr;
        @(negedge clk);
        req_valid = 1'b0;
        if (!err && wait_on && (idx == 9 || idx == 10)) begin
            check("R8", "wait cycle {ready,err,sel}", {rsp_ready, rsp_error, slave_sel},
                  {1'b0, 1'b0, esel});
            @(negedge clk);
        end
        check(tag, $sformatf("addr %h {ready,err,sel}", addr),
              {rsp_ready, rsp_error, slave_sel}, {1'b1, err, esel});
        @(negedge clk);
        check("R7", "idle after response {ready,err,sel}",
              {rsp_ready, rsp_error, slave_sel}, {1'b0, 1'b0, 16'h0});
    endtask

    task automatic sweep(input bit remapped, input bit wait_on);
        tcm_wait_en = wait_on;
        for (int b = 0; b < 16; b++) begin
            if (BANK_CODE[b] != 5'd18) begin
                run_req({4'(b), 28'h0000000}, BANK_CODE[b], remapped, wait_on);
                run_req({4'(b), 28'hFFFFFFF}, BANK_CODE[b], remapped, wait_on);
            end
        end
        for (int r = 0; r < 16; r++) begin
            run_req({4'h0, 8'(r), 20'h00000}, REGION_CODE[r], remapped, wait_on);
            run_req({4'h0, 8'(r), 20'hFFFFF}, REGION_CODE[r], remapped, wait_on);
        end
        run_req(32'h0FFFFFFF, 5'd16, remapped, wait_on);
        run_req(32'h0A000000, 5'd16, remapped, wait_on);
    endtask

    task automatic pulse_remap;
        @(negedge clk);
        remap_pulse = 1'b1;
        @(negedge clk);
        remap_pulse = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R9", "in reset {ready,err,sel}", {rsp_ready, rsp_error, slave_sel}, 18'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R9", "after reset {ready,err,sel}", {rsp_ready, rsp_error, slave_sel}, 18'h0);
        run_req(32'h00000000, 5'd17, 1'b0, 1'b0); // R4 reset value of remap

        sweep(1'b0, 1'b0);
        sweep(1'b0, 1'b1);
        pulse_remap();
        sweep(1'b1, 1'b0);
        sweep(1'b1, 1'b1);

        // R5: remap stays set after a second pulse and further idle cycles
        pulse_remap();
        repeat (5) @(negedge clk);
        run_req(32'h00012340, 5'd17, 1'b1, 1'b0);
        run_req(32'h00300010, 5'd11, 1'b1, 1'b0); // R3 SRAM still at own region

        // R9/R5: reset clears remap, ROM back in boot window
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check("R9", "reset mid-run {ready,err,sel}", {rsp_ready, rsp_error, slave_sel}, 18'h0);
        rst_n = 1'b1;
        run_req(32'h00000004, 5'd17, 1'b0, 1'b0);

        // R8: wait bit irrelevant to non-TCM internal targets
        run_req(32'h00400000, 5'd8, 1'b0, 1'b1);
        run_req(32'h00200000, 5'd10, 1'b0, 1'b1);

        finished = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule